// File: doc/BRIEF.md
# Break and Carrier Status Interrupt Unit

This unit watches two conditions on a serial port and reports them through a small latched status byte and one interrupt request. The first condition is a line break. The receive line is held low through a whole character frame: the start bit, every data bit and the stop-bit slot. The unit counts bit-time ticks while the line stays low to find this. The second condition is the level of a carrier-detect pin. The unit filters this pin so that short glitches are ignored, and reports the carrier in inverted form, so that a low pin reads as carrier present.

While the interrupt is enabled, any change of either status bit raises the request and freezes the status byte. The host therefore reads the values that caused the request. The host clears the request with a one-cycle status-reset strobe. The same strobe also resamples the live conditions. A break produces two separate requests: one when it begins and one when it ends. The host must issue a status reset after each request, and detection is armed again only after the second one. While the interrupt is disabled, the status byte follows the live conditions and no request is raised.

All ports are plain control and status signals. No data stream passes through the unit, so there is no valid/ready handshake and no back-pressure. The receive line and the carrier pin must already be synchronised to `clk`. The bit tick is a one-cycle pulse from an external baud generator.

Top module: `esc_status_irq`

## Requirements
- R1: After reset, `status_byte` is 0x00 and `irq` is 0, provided `cd_pin_n` is high and `rxd` is high.
- R2: `status_byte` bit 3 is the inverse of the filtered carrier pin, so a low pin reads as 1. Bit 7 is the break flag. All other bits are 0.
- R3: A new carrier-pin level is accepted only after it has been present on 4 consecutive clock samples. Bit 3 then changes one clock later, which is 5 clocks after the pin changed. A level that lasts 3 clocks or fewer leaves bit 3 unchanged.
- R4: The break condition becomes true on the 10th bit tick (FRAME_BITS) counted while `rxd` stays low. It becomes false on the first clock where `rxd` is high. Fewer low ticks never set it.
- R5: While `int_en` is 1 and no request is pending, a change of the live break or carrier condition sets `irq` one clock later and latches the new value into the status byte.
- R6: While a request is pending, `status_byte` holds its value, whatever the inputs do.
- R7: A one-cycle `st_reset` pulse clears `irq` and loads the live conditions into `status_byte` without raising a new request.
- R8: The end of a break raises a second request with bit 7 equal to 0. After that request is reset, a new break is needed to raise another request.
- R9: While `int_en` is 0, `status_byte` tracks the live conditions one clock behind and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Synchronised receive-data line, idles high |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cd_pin_n | input | 1 | Synchronised carrier-detect pin, active low |
| int_en | input | 1 | Enables the status-change interrupt |
| st_reset | input | 1 | One-cycle status-reset command strobe |
| status_byte | output | 8 | Bit 7 = break, bit 3 = carrier, other bits 0 |
| irq | output | 1 | Status-change interrupt request |

## Verification
The hardest situation to reach from the ports is the end-of-break request. The stimulus first holds `rxd` low through ten ticks, then clears the start request with `st_reset`, and checks that further low ticks raise nothing. Only after that does it release the line, so that the second request appears with bit 7 at 0. Freezing is tested by raising a carrier request and then letting both the pin and the break condition move while that request is still pending. Then a status reset checks that the live values appear without a new request.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int STAT_W   = 8;
  localparam int BRK_POS  = 7;
  localparam int CAR_POS  = 3;

  typedef struct packed {
    logic brk;
    logic car;
  } esc_cond_t;

  function automatic logic [STAT_W-1:0] pack_status(esc_cond_t c);
    logic [STAT_W-1:0] b;
    b = '0;
    b[BRK_POS] = c.brk;
    b[CAR_POS] = c.car;
    return b;
  endfunction
endpackage

// File: rtl/esc_break_det.sv
module esc_break_det #(
  parameter int FRAME_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic bit_tick,
  output logic brk_live
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      brk_live <= 1'b0;
    end else if (rxd) begin
      low_cnt  <= '0;
      brk_live <= 1'b0;
    end else if (bit_tick && !brk_live) begin
      if (low_cnt == LAST) begin
        brk_live <= 1'b1;
        low_cnt  <= '0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assert_break_rise_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_live) |-> ($past(!rxd) && $past(bit_tick)));
  assert_break_fall_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_live) |-> $past(rxd));
endmodule

// File: rtl/esc_cd_filter.sv
module esc_cd_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic car_live
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          level_q;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_cnt <= '0;
    end else if (pin_n == level_q) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      level_q <= pin_n;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign car_live = ~level_q;

  assert_filter_follows_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(pin_n) == level_q));
endmodule

// File: rtl/esc_stat_latch.sv
module esc_stat_latch
  import esc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  esc_cond_t live,
  input  logic      int_en,
  input  logic      st_reset,
  output esc_cond_t held,
  output logic      pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      pend <= 1'b0;
    end else if (!int_en || st_reset) begin
      held <= live;
      pend <= 1'b0;
    end else if (!pend && (live != held)) begin
      held <= live;
      pend <= 1'b1;
    end
  end

  assert_frozen_while_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && int_en && !st_reset) |=> $stable(held));
  assert_disabled_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !pend);
  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_reset |=> !pend);
endmodule

// File: rtl/esc_status_irq.sv
module esc_status_irq
  import esc_pkg::*;
#(
  parameter int FRAME_BITS = 10,
  parameter int FILT_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              bit_tick,
  input  logic              cd_pin_n,
  input  logic              int_en,
  input  logic              st_reset,
  output logic [STAT_W-1:0] status_byte,
  output logic              irq
);
  esc_cond_t live, held;
  logic      brk_live, car_live;

  esc_break_det #(.FRAME_BITS(FRAME_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_tick(bit_tick), .brk_live(brk_live));

  esc_cd_filter #(.FILT_LEN(FILT_LEN)) u_cd (
    .clk(clk), .rst_n(rst_n), .pin_n(cd_pin_n), .car_live(car_live));

  always_comb begin
    live.brk = brk_live;
    live.car = car_live;
  end

  esc_stat_latch u_lat (
    .clk(clk), .rst_n(rst_n), .live(live), .int_en(int_en),
    .st_reset(st_reset), .held(held), .pend(irq));

  assign status_byte = pack_status(held);

  assert_irq_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status_byte != $past(status_byte)));
  assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte & ~8'h88) == 8'h00);
endmodule

// File: tb/esc_status_irq_test.sv
module esc_status_irq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, rxd = 1, bit_tick = 0, cd_pin_n = 1, int_en = 0, st_reset = 0;
  logic [7:0] status_byte;
  logic irq;
  int checks = 0, errors = 0, cycles = 0;

  esc_status_irq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick;
    bit_tick = 1; clks(1); bit_tick = 0; clks(3);
  endtask

  task automatic do_reset_cmd;
    st_reset = 1; clks(1); st_reset = 0; clks(1);
  endtask

  task automatic t_reset_state;
    chk("R1 status", status_byte, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_filter_disabled;
    int_en = 0;
    cd_pin_n = 0; clks(3); cd_pin_n = 1; clks(8);
    chk("R3 glitch ignored", status_byte, 8'h00);
    cd_pin_n = 0; clks(4);
    chk("R3 not yet after 4", status_byte, 8'h00);
    clks(1);
    chk("R2 carrier bit3", status_byte, 8'h08);
    chk("R9 no irq disabled", {7'b0, irq}, 8'h00);
    cd_pin_n = 1; clks(6);
    chk("R9 tracks carrier loss", status_byte, 8'h00);
  endtask

  task automatic t_carrier_irq_freeze;
    int_en = 1; clks(2);
    cd_pin_n = 0; clks(5);
    chk("R5 irq on carrier", {7'b0, irq}, 8'h01);
    chk("R5 latched carrier", status_byte, 8'h08);
    cd_pin_n = 1; rxd = 0;
    for (int i = 0; i < 10; i++) tick();
    clks(2);
    chk("R6 frozen status", status_byte, 8'h08);
    do_reset_cmd();
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);
    chk("R7 live sampled", status_byte, 8'h80);
    rxd = 1; clks(3);
    chk("R8 break end irq", {7'b0, irq}, 8'h01);
    chk("R8 break bit low", status_byte, 8'h00);
    do_reset_cmd();
  endtask

  task automatic t_break_cycle;
    rxd = 0;
    for (int i = 0; i < 9; i++) tick();
    chk("R4 nine ticks no break", status_byte, 8'h00);
    chk("R4 nine ticks no irq", {7'b0, irq}, 8'h00);
    tick();
    chk("R4 break set", status_byte, 8'h80);
    chk("R5 break start irq", {7'b0, irq}, 8'h01);
    do_reset_cmd();
    chk("R7 cleared break irq", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 5; i++) tick();
    chk("R8 no repeat while low", {7'b0, irq}, 8'h00);
    chk("R8 bit7 still set", status_byte, 8'h80);
    rxd = 1; clks(3);
    chk("R8 end irq", {7'b0, irq}, 8'h01);
    chk("R8 end bit7 clear", status_byte, 8'h00);
    do_reset_cmd();
    rxd = 0;
    for (int i = 0; i < 3; i++) tick();
    rxd = 1; clks(3);
    chk("R4 short low no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_break_disabled;
    int_en = 0; rxd = 0;
    for (int i = 0; i < 10; i++) tick();
    chk("R9 break tracked", status_byte, 8'h80);
    chk("R9 break no irq", {7'b0, irq}, 8'h00);
    rxd = 1; clks(3);
    chk("R9 break end tracked", status_byte, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clks(3);
    rst_n = 1;
    clks(2);
    t_reset_state();
    t_filter_disabled();
    t_carrier_irq_freeze();
    t_break_cycle();
    t_break_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule